// File: doc/BRIEF.md
# Path Signal Label Mismatch Detector

This block watches the signal label byte of a received high-order path. Once per frame the framer presents the received label together with a one-cycle frame strobe. The block compares the received label against a programmable expected label. It raises a mismatch status once the label has disagreed for a run of frames without a break. It drops the status again after a run of agreeing frames of the same length. The run length is 3 or 5 frames, chosen by a single configuration bit.

A separate label-unstable indication, produced elsewhere, can be coupled into the result. When the coupling bit is set, an active unstable input forces the mismatch status on. When the unstable input goes away, the status falls back to whatever the frame-persistence logic holds at that moment. When the coupling bit is clear, the two conditions stay separate. A one-cycle change pulse marks every transition of the status output.

Top module: `sig_label_mon`

## Requirements
- R1: While `rst` is high at a clock edge, the internal run count and internal status clear. After that edge `mismatch_st` and `mismatch_chg` read 0.
- R2: With `thr_sel` = 0 and the status clear, the internal status sets on the third consecutive strobed mismatching frame. `mismatch_st` goes to 1 one clock after the edge that samples that third strobe.
- R3: With `thr_sel` = 1, five consecutive strobed mismatching frames are needed to set the status. Four are not enough.
- R4: While the status is clear, a strobed frame whose label equals `exp_label` restarts the mismatch run from zero.
- R5: While the status is set, it clears after the same number of consecutive strobed matching frames as the selected threshold (3 or 5). A mismatching frame restarts that run.
- R6: Clock edges with `frame_stb` = 0 leave the run count and the status untouched, whatever `rx_label` holds.
- R7: With `unstab_cpl_en` = 1, an active `label_unstable` sampled at an edge makes `mismatch_st` read 1 after the next edge. When the input is removed, the output returns to the internal status.
- R8: With `unstab_cpl_en` = 0, `label_unstable` has no effect, and `mismatch_st` follows the internal status with one clock of delay.
- R9: `mismatch_chg` is 1 for exactly the cycles in which `mismatch_st` differs from its value in the previous cycle.
- R10: Labels are compared on all `LABEL_W` bits. A received label differing from `exp_label` in any single bit counts as a mismatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_stb | input | 1 | One-cycle strobe marking a new received label |
| rx_label | input | LABEL_W | Received signal label, valid with `frame_stb` |
| exp_label | input | LABEL_W | Programmed expected label |
| thr_sel | input | 1 | Run length: 0 = 3 frames, 1 = 5 frames |
| unstab_cpl_en | input | 1 | 1 = unstable indication forces the mismatch status |
| label_unstable | input | 1 | Label-unstable indication from outside the block |
| mismatch_st | output | 1 | Registered mismatch status |
| mismatch_chg | output | 1 | One-cycle pulse on every change of `mismatch_st` |

## Verification
The frame-persistence logic and the unstable override can act in the same cycle. For example, the third mismatching frame may land on the same edge where the unstable input is asserted or released. In that case the forced value and the newly computed internal status meet at the output register. Directed sequences line up a threshold-completing strobe with an unstable edge, and the random phase toggles the unstable input and the coupling bit while labels run in streaks. A cycle-level reference model in the bench judges every cycle on both the status and the change pulse, so a lost or doubled pulse at such a collision is caught.

// File: rtl/slm_pkg.sv
package slm_pkg;

  typedef enum logic {
    ST_CLEAR = 1'b0,
    ST_ALARM = 1'b1
  } slm_state_e;

  // Run length chosen by the select bit.
  function automatic int unsigned run_len(input logic sel, input int unsigned lo,
                                          input int unsigned hi);
    return sel ? hi : lo;
  endfunction

endpackage

// File: rtl/slm_compare.sv
module slm_compare #(
  parameter int LABEL_W = 8
) (
  input  logic               frame_stb,
  input  logic [LABEL_W-1:0] rx_label,
  input  logic [LABEL_W-1:0] exp_label,
  output logic               frame_vld,
  output logic               frame_mism
);

  logic [LABEL_W-1:0] bit_diff;

  for (genvar i = 0; i < LABEL_W; i++) begin : g_bit
    assign bit_diff[i] = rx_label[i] ^ exp_label[i];
  end

  assign frame_vld  = frame_stb;
  assign frame_mism = |bit_diff;

endmodule

// File: rtl/slm_persist.sv
module slm_persist
  import slm_pkg::*;
#(
  parameter int THR_LO = 3,
  parameter int THR_HI = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_vld,
  input  logic frame_mism,
  input  logic thr_sel,
  output logic raw_st
);

  localparam int CNT_W = $clog2(THR_HI + 1);

  slm_state_e         state;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   cnt_inc;
  logic [CNT_W-1:0]   thr;
  logic               toward;

  assign cnt_inc = cnt + 1'b1;
  assign thr     = CNT_W'(run_len(thr_sel, THR_LO, THR_HI));
  // A frame pushes toward a flip when it disagrees with the present state.
  assign toward  = (state == ST_CLEAR) ? frame_mism : ~frame_mism;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_CLEAR;
      cnt   <= '0;
    end else if (frame_vld) begin
      if (!toward) begin
        cnt <= '0;
      end else if (cnt_inc >= thr) begin
        cnt   <= '0;
        state <= (state == ST_CLEAR) ? ST_ALARM : ST_CLEAR;
      end else begin
        cnt <= cnt_inc;
      end
    end
  end

  assign raw_st = (state == ST_ALARM);

  // R6: edges without a strobe leave count and status alone
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !frame_vld |=> ($stable(cnt) && $stable(state)));

  // R2/R3: the run count never reaches the larger threshold
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt < CNT_W'(THR_HI));

  // R4: an agreeing frame while clear empties the run
  a_r4_restart: assert property (@(posedge clk) disable iff (rst)
    (frame_vld && !frame_mism && state == ST_CLEAR) |=> (cnt == '0 && state == ST_CLEAR));

  // R5: a mismatching frame while set keeps the status set
  a_r5_hold_set: assert property (@(posedge clk) disable iff (rst)
    (frame_vld && frame_mism && state == ST_ALARM) |=> (cnt == '0 && state == ST_ALARM));

endmodule

// File: rtl/slm_output.sv
module slm_output (
  input  logic clk,
  input  logic rst,
  input  logic raw_st,
  input  logic cpl_en,
  input  logic unstable,
  output logic mismatch_st,
  output logic mismatch_chg
);

  logic st_next;

  assign st_next = raw_st | (cpl_en & unstable);

  always_ff @(posedge clk) begin
    if (rst) begin
      mismatch_st  <= 1'b0;
      mismatch_chg <= 1'b0;
    end else begin
      mismatch_st  <= st_next;
      mismatch_chg <= st_next ^ mismatch_st;
    end
  end

  // R7: coupled unstable forces the status on the next cycle
  a_r7_force: assert property (@(posedge clk) disable iff (rst)
    (cpl_en && unstable) |=> mismatch_st);

  // R8: without forcing, output tracks the internal status one cycle later
  a_r8_follow: assert property (@(posedge clk) disable iff (rst)
    !(cpl_en && unstable) |=> (mismatch_st == $past(raw_st)));

  // R9: every status transition carries a pulse
  a_r9_pulse: assert property (@(posedge clk) disable iff (rst)
    (mismatch_st != $past(mismatch_st)) |-> mismatch_chg);

endmodule

// File: rtl/sig_label_mon.sv
module sig_label_mon #(
  parameter int LABEL_W = 8,
  parameter int THR_LO  = 3,
  parameter int THR_HI  = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_stb,
  input  logic [LABEL_W-1:0] rx_label,
  input  logic [LABEL_W-1:0] exp_label,
  input  logic               thr_sel,
  input  logic               unstab_cpl_en,
  input  logic               label_unstable,
  output logic               mismatch_st,
  output logic               mismatch_chg
);

  logic frame_vld;
  logic frame_mism;
  logic raw_st;

  slm_compare #(.LABEL_W(LABEL_W)) u_cmp (
    .frame_stb (frame_stb),
    .rx_label  (rx_label),
    .exp_label (exp_label),
    .frame_vld (frame_vld),
    .frame_mism(frame_mism)
  );

  slm_persist #(.THR_LO(THR_LO), .THR_HI(THR_HI)) u_pers (
    .clk       (clk),
    .rst       (rst),
    .frame_vld (frame_vld),
    .frame_mism(frame_mism),
    .thr_sel   (thr_sel),
    .raw_st    (raw_st)
  );

  slm_output u_out (
    .clk         (clk),
    .rst         (rst),
    .raw_st      (raw_st),
    .cpl_en      (unstab_cpl_en),
    .unstable    (label_unstable),
    .mismatch_st (mismatch_st),
    .mismatch_chg(mismatch_chg)
  );

  // R1: reset clears both outputs
  a_r1_reset: assert property (@(posedge clk)
    rst |=> (!mismatch_st && !mismatch_chg));

endmodule

// File: tb/tb_sig_label_mon.sv
`timescale 1ns/1ps
module tb_sig_label_mon;

  logic       clk = 1'b0;
  logic       rst;
  logic       frame_stb;
  logic [7:0] rx_label;
  logic [7:0] exp_label;
  logic       thr_sel;
  logic       unstab_cpl_en;
  logic       label_unstable;
  logic       mismatch_st;
  logic       mismatch_chg;

  always #10 clk = ~clk;

  sig_label_mon dut (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .rx_label(rx_label),
    .exp_label(exp_label), .thr_sel(thr_sel), .unstab_cpl_en(unstab_cpl_en),
    .label_unstable(label_unstable), .mismatch_st(mismatch_st),
    .mismatch_chg(mismatch_chg)
  );

  int  checks = 0;
  int  errors = 0;
  bit  done   = 0;

  // reference model state
  bit m_raw, m_st, m_chg;
  int m_cnt;

  function automatic int thr_of(input bit sel);
    return sel ? 5 : 3;
  endfunction

  function automatic bit is_mism(input logic [7:0] a, input logic [7:0] b);
    return a != b;
  endfunction

  task automatic model_edge();
    bit nst, toward;
    if (rst) begin
      m_raw = 0; m_st = 0; m_chg = 0; m_cnt = 0;
    end else begin
      nst   = m_raw | (unstab_cpl_en & label_unstable);
      m_chg = nst != m_st;
      m_st  = nst;
      if (frame_stb) begin
        toward = m_raw ? !is_mism(rx_label, exp_label) : is_mism(rx_label, exp_label);
        if (!toward) m_cnt = 0;
        else if (m_cnt + 1 >= thr_of(thr_sel)) begin
          m_cnt = 0; m_raw = !m_raw;
        end else m_cnt = m_cnt + 1;
      end
    end
  endtask

  task automatic check(input string tag, input logic act, input bit exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // One clock: drive at negedge, model at posedge, check at next negedge.
  task automatic step(input bit stb, input logic [7:0] lbl, input bit unst, input string tag);
    frame_stb = stb; rx_label = lbl; label_unstable = unst;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag, mismatch_st, m_st, "mismatch_st");
    check("R9", mismatch_chg, m_chg, "mismatch_chg");
  endtask

  task automatic frames(input int n, input logic [7:0] lbl, input string tag);
    for (int i = 0; i < n; i++) step(1, lbl, 0, tag);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1; frame_stb = 0; rx_label = 0; exp_label = 8'h13;
    thr_sel = 0; unstab_cpl_en = 0; label_unstable = 0;
    @(negedge clk);
    step(0, 8'h00, 0, "R1");
    step(0, 8'h00, 0, "R1");
    rst = 0;

    // R2: three mismatches, with a match interrupting first (R4)
    frames(2, 8'h55, "R2");
    step(1, 8'h13, 0, "R4");
    frames(2, 8'h55, "R4");
    step(0, 8'hAA, 0, "R6");
    step(1, 8'h55, 0, "R2");
    step(0, 8'h13, 0, "R2");
    check("R2", mismatch_st, 1'b1, "status after third mismatch");

    // R5: clear needs three agreeing frames in a row; idle frames ignored (R6)
    frames(2, 8'h13, "R5");
    step(1, 8'h14, 0, "R5");
    frames(2, 8'h13, "R5");
    step(0, 8'h13, 0, "R6");
    check("R6", mismatch_st, 1'b1, "status held over idle edge");
    step(1, 8'h13, 0, "R5");
    step(0, 8'h00, 0, "R5");
    check("R5", mismatch_st, 1'b0, "status after clear run");

    // R3 and R10: five single-bit-different labels
    thr_sel = 1;
    for (int b = 0; b < 4; b++) step(1, exp_label ^ (8'h1 << b), 0, "R10");
    step(0, 8'h00, 0, "R3");
    check("R3", mismatch_st, 1'b0, "four mismatches at threshold five");
    step(1, exp_label ^ 8'h80, 0, "R3");
    step(0, 8'h00, 0, "R3");
    check("R3", mismatch_st, 1'b1, "five mismatches at threshold five");
    frames(5, 8'h13, "R5");
    step(0, 8'h00, 0, "R5");

    // R8: unstable ignored without coupling
    thr_sel = 0;
    for (int i = 0; i < 4; i++) step(0, 8'h00, 1, "R8");
    check("R8", mismatch_st, 1'b0, "uncoupled unstable");

    // R7: forcing and release, plus collision with a threshold edge
    unstab_cpl_en = 1;
    step(0, 8'h00, 1, "R7");
    step(0, 8'h00, 1, "R7");
    check("R7", mismatch_st, 1'b1, "forced on");
    step(0, 8'h00, 0, "R7");
    step(0, 8'h00, 0, "R7");
    check("R7", mismatch_st, 1'b0, "revert after release");
    frames(2, 8'hF0, "R7");
    step(1, 8'hF0, 1, "R7");   // third mismatch and force in one edge
    step(0, 8'h00, 0, "R7");   // release lands as internal status takes over
    step(0, 8'h00, 0, "R7");
    check("R7", mismatch_st, 1'b1, "internal status after release");

    // random phase
    for (int n = 0; n < 6000; n++) begin
      logic [7:0] l;
      bit stb, unst;
      if (($urandom % 200) == 0) thr_sel = $urandom % 2;
      if (($urandom % 150) == 0) unstab_cpl_en = $urandom % 2;
      if (($urandom % 300) == 0) exp_label = $urandom;
      if (($urandom % 40) == 0) rx_label = ($urandom % 2) ? exp_label : 8'($urandom);
      l = (($urandom % 8) == 0) ? 8'($urandom) : rx_label;
      stb  = ($urandom % 3) != 0;
      unst = (($urandom % 30) == 0) ? !label_unstable : label_unstable;
      step(stb, l, unst, unst ? "R7" : (stb ? "R2" : "R6"));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule